// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and the next memory level. It takes single-word stores and collects them in a small queue of entries. Each entry covers one aligned block of four 32-bit words and records which words have been written. A store to a block that already has an open entry goes into that entry, so a run of stores to neighbouring words leaves as one memory transaction instead of several. Entries leave for memory strictly oldest first, one entry per write transaction. The transaction carries a word strobe mask that marks the written words.

A read miss from the cache is looked up against every buffered entry in the same cycle. The lookup returns the newest buffered copy of the requested word and the union of written words in that block. It also flags a partial hit, so the requester knows it must still fetch the missing words from memory. Reads that the buffer cannot fully cover use the memory port ahead of queued writes, unless a write transaction is already under way. A write that has started keeps the port until memory accepts it, and its entry no longer takes merges. A later store to that block opens a fresh entry.

Top module: `merge_wbuf`

## Requirements
- R1: After a synchronous reset the buffer is empty: `mem_valid` is 0, `st_ready` is 1, and no lookup reports a block hit.
- R2: Byte address bits [3:2] pick the word inside a 16-byte aligned block and bits [31:4] are the block tag. Stores to different words of one block that is open (buffered and not being written out) fill a single entry. Four such stores leave as one write with strobe `1111`.
- R3: A store to a word that is already written in an open entry replaces that word's data. The strobe mask does not change.
- R4: When every entry is in use and a store matches no open entry, `st_ready` is 0 and the store is not taken. A store that matches an open entry is still accepted (`st_ready` 1) while the buffer is full.
- R5: An entry on the memory port, or one that has started a write, accepts no merge. A store to its block allocates a new entry. Both entries later drain, each with its own data.
- R6: Entries drain oldest first, one per write transaction: `mem_write` 1, `mem_addr` the block base address, word i on `mem_data[32*i+31:32*i]`, and strobe bit i set only for written words. The transaction stays unchanged until `mem_ready` is 1.
- R7: The lookup at `rd_addr` searches all entries, including one being written out. `rd_blk_hit` is 1 if any entry holds the block. `rd_mask` is the union of written words. `rd_word`/`rd_word_hit` give the newest buffered value of the addressed word. `rd_partial` is 1 when the block hits but `rd_mask` is not `1111`.
- R8: While `rd_valid` is 1, the lookup is not a full hit, and no write has started, the memory port carries the read instead of a drain: `mem_write` 0, `mem_addr` the read block base, strobe `1111`. A full hit leaves the port to draining.
- R9: A write already started is not replaced by a later read request. It stays on the port until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store word |
| st_ready | output | 1 | Store taken at this edge when high with st_valid |
| rd_valid | input | 1 | Read miss needs the memory port |
| rd_addr | input | 32 | Read miss byte address (lookup is always active) |
| rd_blk_hit | output | 1 | Some entry holds the read block |
| rd_word_hit | output | 1 | Addressed word is buffered |
| rd_word | output | 32 | Newest buffered value of the addressed word |
| rd_mask | output | 4 | Buffered words of the read block |
| rd_partial | output | 1 | Block hit with some words missing |
| mem_valid | output | 1 | Memory transaction request |
| mem_write | output | 1 | 1 write drain, 0 read fetch |
| mem_addr | output | 32 | Block base byte address |
| mem_data | output | 128 | Drain data, word i at bits 32*i+31:32*i |
| mem_strb | output | 4 | Word strobes of the drain |
| mem_ready | input | 1 | Memory accepts the transaction |

## Verification
The bench builds the block with its default depth of four entries, so only five distinct blocks are needed to fill the buffer and exercise the full stall together with merging into a full buffer. A read request that memory never accepts holds the port off from draining. This keeps the first entry open, so merging and overwriting can be seen before any write starts. Memory acceptance is then released one transaction at a time to observe drain order, hold behaviour and the split of one block into two entries.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 4;
    localparam int ADDR_W    = 32;
    localparam int WIDX_W    = $clog2(BLK_WORDS);
    localparam int BOFS      = WIDX_W + 2;
    localparam int TAG_W     = ADDR_W - BOFS;

    typedef logic [WORD_W-1:0]    word_t;
    typedef logic [TAG_W-1:0]     tag_t;
    typedef logic [BLK_WORDS-1:0] wmask_t;
    typedef logic [WIDX_W-1:0]    widx_t;
    typedef word_t [BLK_WORDS-1:0] line_t;

    typedef struct packed {
        logic   used;
        logic   busy;
        tag_t   tag;
        wmask_t mask;
        line_t  data;
    } ent_t;

    typedef enum logic [1:0] {
        PORT_IDLE,
        PORT_RD,
        PORT_WR
    } port_sel_e;

    function automatic tag_t tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:BOFS];
    endfunction

    function automatic widx_t widx_of(input logic [ADDR_W-1:0] a);
        return a[BOFS-1:2];
    endfunction

    function automatic logic [ADDR_W-1:0] base_of(input tag_t t);
        return {t, {BOFS{1'b0}}};
    endfunction

endpackage

// File: rtl/wbuf_merge_find.sv
module wbuf_merge_find
    import wbuf_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic          e_used [DEPTH],
    input  logic          e_busy [DEPTH],
    input  tag_t          e_tag  [DEPTH],
    input  logic [PW-1:0] head,
    input  logic          drain_now,
    input  tag_t          st_tag,
    output logic          hit,
    output logic [PW-1:0] idx
);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (e_used[i] && !e_busy[i] && (e_tag[i] == st_tag) &&
                !(drain_now && (PW'(i) == head))) begin
                hit = 1'b1;
                idx = PW'(i);
            end
        end
    end

endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd
    import wbuf_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic          e_used [DEPTH],
    input  tag_t          e_tag  [DEPTH],
    input  wmask_t        e_mask [DEPTH],
    input  line_t         e_data [DEPTH],
    input  logic [PW-1:0] head,
    input  tag_t          rd_tag,
    input  widx_t         rd_widx,
    output logic          blk_hit,
    output wmask_t        mask,
    output logic          word_hit,
    output word_t         word
);

    line_t         merged;
    logic [PW-1:0] fidx;

    // walk oldest to newest so the youngest copy of each word wins
    always_comb begin
        blk_hit = 1'b0;
        mask    = '0;
        merged  = '0;
        fidx    = '0;
        for (int k = 0; k < DEPTH; k++) begin
            fidx = head + PW'(k);
            if (e_used[fidx] && (e_tag[fidx] == rd_tag)) begin
                blk_hit = 1'b1;
                for (int w = 0; w < BLK_WORDS; w++) begin
                    if (e_mask[fidx][w]) begin
                        mask[w]   = 1'b1;
                        merged[w] = e_data[fidx][w];
                    end
                end
            end
        end
    end

    assign word_hit = mask[rd_widx];
    assign word     = merged[rd_widx];

endmodule

// File: rtl/wbuf_port_arb.sv
module wbuf_port_arb
    import wbuf_pkg::*;
(
    input  logic              rd_valid,
    input  logic              rd_need,
    input  ent_t              head_ent,
    input  tag_t              rd_tag,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output line_t             mem_line,
    output wmask_t            mem_strb,
    output logic              drain_now
);

    port_sel_e sel;

    always_comb begin
        if (head_ent.used && head_ent.busy)
            sel = PORT_WR;
        else if (rd_valid && rd_need)
            sel = PORT_RD;
        else if (head_ent.used)
            sel = PORT_WR;
        else
            sel = PORT_IDLE;
    end

    assign mem_valid = (sel != PORT_IDLE);
    assign mem_write = (sel == PORT_WR);
    assign mem_addr  = mem_write ? base_of(head_ent.tag) : base_of(rd_tag);
    assign mem_line  = head_ent.data;
    assign mem_strb  = mem_write ? head_ent.mask : '1;
    assign drain_now = mem_write;

endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
    import wbuf_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        st_valid,
    input  logic [ADDR_W-1:0]           st_addr,
    input  logic [WORD_W-1:0]           st_data,
    output logic                        st_ready,
    input  logic                        rd_valid,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic                        rd_blk_hit,
    output logic                        rd_word_hit,
    output logic [WORD_W-1:0]           rd_word,
    output logic [BLK_WORDS-1:0]        rd_mask,
    output logic                        rd_partial,
    output logic                        mem_valid,
    output logic                        mem_write,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [BLK_WORDS*WORD_W-1:0] mem_data,
    output logic [BLK_WORDS-1:0]        mem_strb,
    input  logic                        mem_ready
);

    ent_t          ents [DEPTH];
    logic [PW-1:0] head, tail;
    logic [PW:0]   cnt;

    logic   e_used [DEPTH];
    logic   e_busy [DEPTH];
    tag_t   e_tag  [DEPTH];
    wmask_t e_mask [DEPTH];
    line_t  e_data [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_split
        assign e_used[g] = ents[g].used;
        assign e_busy[g] = ents[g].busy;
        assign e_tag[g]  = ents[g].tag;
        assign e_mask[g] = ents[g].mask;
        assign e_data[g] = ents[g].data;
    end

    logic [1:0] unused_lanes;
    assign unused_lanes = st_addr[1:0] ^ rd_addr[1:0];

    tag_t  st_tag, rd_tag;
    widx_t st_widx, rd_widx;
    assign st_tag  = tag_of(st_addr);
    assign st_widx = widx_of(st_addr);
    assign rd_tag  = tag_of(rd_addr);
    assign rd_widx = widx_of(rd_addr);

    logic          drain_now, m_hit;
    logic [PW-1:0] m_idx;
    line_t         mem_line;

    wbuf_merge_find #(.DEPTH(DEPTH)) u_find (
        .e_used(e_used), .e_busy(e_busy), .e_tag(e_tag),
        .head(head), .drain_now(drain_now), .st_tag(st_tag),
        .hit(m_hit), .idx(m_idx)
    );

    wbuf_fwd #(.DEPTH(DEPTH)) u_fwd (
        .e_used(e_used), .e_tag(e_tag), .e_mask(e_mask), .e_data(e_data),
        .head(head), .rd_tag(rd_tag), .rd_widx(rd_widx),
        .blk_hit(rd_blk_hit), .mask(rd_mask),
        .word_hit(rd_word_hit), .word(rd_word)
    );

    logic rd_need;
    assign rd_partial = rd_blk_hit && !(&rd_mask);
    assign rd_need    = !(rd_blk_hit && (&rd_mask));

    wbuf_port_arb u_arb (
        .rd_valid(rd_valid), .rd_need(rd_need), .head_ent(ents[head]),
        .rd_tag(rd_tag), .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_line(mem_line), .mem_strb(mem_strb),
        .drain_now(drain_now)
    );
    assign mem_data = mem_line;

    logic full, do_merge, do_alloc, pop;
    assign full     = (cnt == (PW+1)'(DEPTH));
    assign st_ready = m_hit || !full;
    assign do_merge = st_valid && m_hit;
    assign do_alloc = st_valid && !m_hit && !full;
    assign pop      = drain_now && mem_ready;

    ent_t new_ent;
    always_comb begin
        new_ent               = '0;
        new_ent.used          = 1'b1;
        new_ent.tag           = st_tag;
        new_ent.mask[st_widx] = 1'b1;
        new_ent.data[st_widx] = st_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
            head <= '0;
            tail <= '0;
            cnt  <= '0;
        end else begin
            if (drain_now && !mem_ready) ents[head].busy <= 1'b1;
            if (pop) begin
                ents[head] <= '0;
                head       <= head + 1'b1;
            end
            if (do_merge) begin
                ents[m_idx].mask[st_widx] <= 1'b1;
                ents[m_idx].data[st_widx] <= st_data;
            end
            if (do_alloc) begin
                ents[tail] <= new_ent;
                tail       <= tail + 1'b1;
            end
            cnt <= cnt + (PW+1)'(do_alloc) - (PW+1)'(pop);
        end
    end

endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk
    import wbuf_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int PW    = $clog2(DEPTH)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 st_valid,
    input logic                 st_ready,
    input logic                 rd_valid,
    input logic                 rd_blk_hit,
    input logic                 rd_word_hit,
    input logic                 rd_partial,
    input logic                 mem_valid,
    input logic                 mem_write,
    input logic                 mem_ready,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic [BLK_WORDS-1:0] mem_strb,
    input logic [PW:0]          cnt
);

    // R6
    drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_write && !mem_ready) |=>
            (mem_valid && mem_write && $stable(mem_addr) && $stable(mem_strb)));

    // R2
    strobe_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_write) |-> (mem_strb != '0));

    // R4
    stall_no_take_chk: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_ready && !(mem_valid && mem_write && mem_ready)) |=> $stable(cnt));

    // R8
    read_has_req_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_write) |-> (rd_valid && (!rd_blk_hit || rd_partial)));

    // R7
    word_in_blk_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_word_hit || rd_partial) |-> rd_blk_hit);

    // R6
    drain_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_write) |-> (cnt != '0));

endmodule

bind merge_wbuf wbuf_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/merge_wbuf_test.sv
module merge_wbuf_test;
    import wbuf_pkg::*;

    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         st_valid = 1'b0;
    logic [31:0]  st_addr = '0;
    logic [31:0]  st_data = '0;
    logic         st_ready;
    logic         rd_valid = 1'b0;
    logic [31:0]  rd_addr = '0;
    logic         rd_blk_hit, rd_word_hit, rd_partial;
    logic [31:0]  rd_word;
    logic [3:0]   rd_mask;
    logic         mem_valid, mem_write;
    logic [31:0]  mem_addr;
    logic [127:0] mem_data;
    logic [3:0]   mem_strb;
    logic         mem_ready = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    merge_wbuf #(.DEPTH(4)) uut (.*);

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] d;
        logic        rdy;
    } vec_t;

    localparam vec_t VT [10] = '{
        '{32'h100, 32'hA000_0000, 1'b1},
        '{32'h104, 32'hA000_0001, 1'b1},
        '{32'h108, 32'hA000_0002, 1'b1},
        '{32'h10C, 32'hA000_0003, 1'b1},
        '{32'h104, 32'hA111_0001, 1'b1},
        '{32'h204, 32'hB000_0001, 1'b1},
        '{32'h30C, 32'hC000_0003, 1'b1},
        '{32'h400, 32'hD000_0000, 1'b1},
        '{32'h500, 32'hE000_0000, 1'b0},
        '{32'h208, 32'hB000_0002, 1'b1}
    };

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_store(input string req, input logic [31:0] a, input logic [31:0] d,
                            input logic exp_rdy);
        @(negedge clk);
        st_valid = 1'b1;
        st_addr  = a;
        st_data  = d;
        #1 chk(req, 128'(st_ready), 128'(exp_rdy));
        @(posedge clk);
        #1 st_valid = 1'b0;
    endtask

    task automatic drain_one(input string req, input logic [31:0] a, input logic [3:0] s,
                             input logic [127:0] d);
        logic [127:0] m;
        for (int w = 0; w < 4; w++) m[32*w +: 32] = {32{s[w]}};
        @(negedge clk);
        #1;
        chk({req, " valid/write"}, 128'({mem_valid, mem_write}), 128'(2'b11));
        chk({req, " addr"}, 128'(mem_addr), 128'(a));
        chk({req, " strb"}, 128'(mem_strb), 128'(s));
        chk({req, " data"}, mem_data & m, d & m);
        mem_ready = 1'b1;
        @(posedge clk);
        #1 mem_ready = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        rd_addr = 32'h100;
        #1;
        // R1 reset state
        chk("R1 mem_valid", 128'(mem_valid), 128'(0));
        chk("R1 st_ready", 128'(st_ready), 128'(1));
        chk("R1 blk_hit", 128'(rd_blk_hit), 128'(0));

        // hold the port with a read that memory never accepts (R8)
        rd_valid = 1'b1;
        rd_addr  = 32'h800;
        #1;
        chk("R8 read first", 128'({mem_valid, mem_write}), 128'(2'b10));
        chk("R8 read addr", 128'(mem_addr), 128'(32'h800));

        // table: R2 merge, R3 overwrite, R4 full stall and merge-while-full
        for (int i = 0; i < 10; i++)
            do_store($sformatf("R4/R2 store vector %0d ready", i), VT[i].a, VT[i].d, VT[i].rdy);

        @(negedge clk);
        #1;
        chk("R8 read still held", 128'({mem_valid, mem_write, mem_addr}),
            128'({2'b10, 32'h800}));

        // R7 full block hit with overwritten word
        rd_addr = 32'h104;
        #1;
        chk("R7 blk_hit", 128'(rd_blk_hit), 128'(1));
        chk("R7 mask", 128'(rd_mask), 128'(4'b1111));
        chk("R7 word R3 newest", 128'({rd_word_hit, rd_word}), 128'({1'b1, 32'hA111_0001}));
        chk("R7 partial clear", 128'(rd_partial), 128'(0));
        // R8 full hit: port goes to draining
        chk("R8 full hit drains", 128'({mem_valid, mem_write, mem_addr}),
            128'({2'b11, 32'h100}));

        // R7 partial block; R9 started write not replaced by read
        @(negedge clk);
        rd_addr = 32'h200;
        #1;
        chk("R7 partial mask", 128'({rd_blk_hit, rd_partial, rd_word_hit, rd_mask}),
            128'({3'b110, 4'b0110}));
        chk("R9 write held", 128'({mem_valid, mem_write, mem_addr}), 128'({2'b11, 32'h100}));

        // R5 no merge into a draining entry (buffer also full)
        do_store("R5 store to draining block", 32'h108, 32'hEEEE_0002, 1'b0);

        drain_one("R6 drain block 0x100", 32'h100, 4'b1111,
                  {32'hA000_0003, 32'hA000_0002, 32'hA111_0001, 32'hA000_0000});

        @(negedge clk);
        #1;
        chk("R8 partial read gets port", 128'({mem_valid, mem_write, mem_addr, mem_strb}),
            128'({2'b10, 32'h200, 4'b1111}));
        rd_valid = 1'b0;
        #1;
        chk("R6 drain resumes", 128'({mem_valid, mem_write, mem_addr}), 128'({2'b11, 32'h200}));

        // R5 store to block being written out opens new entry
        do_store("R5 new entry ready", 32'h208, 32'hF000_0002, 1'b1);
        @(negedge clk);
        rd_addr = 32'h208;
        #1;
        chk("R5 R7 newest copy forwarded", 128'({rd_word_hit, rd_word, rd_mask}),
            128'({1'b1, 32'hF000_0002, 4'b0110}));

        drain_one("R5 R6 old block data", 32'h200, 4'b0110,
                  {32'h0, 32'hB000_0002, 32'hB000_0001, 32'h0});
        drain_one("R6 drain 0x300", 32'h300, 4'b1000, {32'hC000_0003, 96'h0});
        drain_one("R6 drain 0x400", 32'h400, 4'b0001, {96'h0, 32'hD000_0000});
        drain_one("R5 R6 drain new entry", 32'h200, 4'b0100,
                  {32'h0, 32'hF000_0002, 32'h0, 32'h0});

        @(negedge clk);
        #1;
        chk("R6 empty after drains", 128'({mem_valid, st_ready, rd_blk_hit}), 128'(3'b010));

        // R1 reset clears pending data
        do_store("R1 store before reset", 32'h600, 32'h6000_0000, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        rd_addr = 32'h600;
        #1;
        chk("R1 reset empties", 128'({mem_valid, st_ready, rd_blk_hit}), 128'(3'b010));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule